// File: doc/BRIEF.md
# Descriptor List Address Sequencer

This block walks a single list of DMA descriptors held in system memory, either the transmit list or the receive list. For each descriptor it works out where the descriptor sits and where its data buffers sit. A design with both directions uses one instance per list, and each instance has its own base-address register. Software loads the base address and then pulses a poll strobe. From then on the sequencer fetches each descriptor as four 32-bit words over a simple request/acknowledge read port. It then offers each non-empty buffer to a data mover as an address and length pair.

The list can be linked in two ways. In ring mode, descriptors sit back to back at a fixed stride, and an end-of-ring flag sends the walk back to the base. In chained mode, the fourth word of a descriptor is a pointer to the next descriptor. A descriptor that the DMA does not own stops the walk in a suspended state. It stays there until software issues another poll.

Top module: `dlist_walker`

## Requirements
- R1: After reset the block is idle: `mem_req`, `xfer_valid` and `suspended` are low and `cur_desc` is zero.
- R2: A `base_wr` pulse always updates the base register. It also loads `cur_desc` with `base_in`, but only while the block is idle or suspended. While a walk is running, `cur_desc` keeps its value.
- R3: A descriptor is read as four words at `cur_desc`, +4, +8 and +12, in that order. Each request holds its address until `mem_ack`. Word 0 carries the owned flag at bit 31 and the last-segment flag at bit 30. Word 1 carries the buffer-1 size in [11:0], the buffer-2 size in [23:12], the chain flag at bit 24 and the end-of-ring flag at bit 25. Word 2 is the buffer-1 address. Word 3 is either the buffer-2 address or the next-descriptor pointer.
- R4: If word 0 shows the descriptor is not owned (bit 31 clear), no further words of it are read and `suspended` rises. A `poll` pulse restarts the walk by re-reading the same descriptor from word 0. A `poll` pulse also starts the walk from idle.
- R5: Buffer 1 is offered before buffer 2 on `xfer_addr`/`xfer_len`. Each offer is held until `xfer_done`.
- R6: A buffer whose size field is zero is skipped, and `xfer_valid` never shows a zero length.
- R7: When the chain flag is set, word 3 is taken as the next descriptor address and no second buffer is offered.
- R8: Without the chain flag, the next descriptor is at `cur_desc` + 16. When end-of-ring is set, the next descriptor is the base address instead.
- R9: `xfer_eof` is high only on the last buffer offered for a descriptor whose last-segment flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_wr | input | 1 | Base-address register write strobe |
| base_in | input | AW | Base address to write |
| poll | input | 1 | Poll-demand strobe: start or resume the walk |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | AW | Descriptor word address |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | DW | Read response data |
| xfer_valid | output | 1 | Buffer offer to the data mover |
| xfer_addr | output | AW | Buffer address |
| xfer_len | output | LEN_W | Buffer length in bytes |
| xfer_eof | output | 1 | This buffer ends the frame |
| xfer_done | input | 1 | Data mover finished the offered buffer |
| suspended | output | 1 | Walk stopped on an unowned descriptor |
| cur_desc | output | AW | Address of the current descriptor |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, 12-bit size fields and a 16-byte stride. It maps a 1 KiB memory window, so ring, chain and wrap targets all fall inside a small modelled memory. A data-mover model with an adjustable delay lets an offer stay pending for many cycles. That delay is what makes it possible to test held offers and a base write arriving in the middle of a walk. Ending each list on an unowned descriptor makes every walk finish in a known suspended state.

// File: rtl/dlist_walker.sv
module dlist_walker #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LEN_W  = 12,
  parameter int STRIDE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_wr,
  input  logic [AW-1:0]    base_in,
  input  logic             poll,
  output logic             mem_req,
  output logic [AW-1:0]    mem_addr,
  input  logic             mem_ack,
  input  logic [DW-1:0]    mem_rdata,
  output logic             xfer_valid,
  output logic [AW-1:0]    xfer_addr,
  output logic [LEN_W-1:0] xfer_len,
  output logic             xfer_eof,
  input  logic             xfer_done,
  output logic             suspended,
  output logic [AW-1:0]    cur_desc
);

  localparam int OWN_BIT = DW - 1;
  localparam int LS_BIT  = DW - 2;
  localparam int SZ2_LO  = LEN_W;
  localparam int CH_BIT  = 2 * LEN_W;
  localparam int EOR_BIT = 2 * LEN_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_RD, S_BUF1, S_BUF2, S_NEXT, S_SUSP} st_t;

  st_t              state;
  logic [1:0]       widx;
  logic [AW-1:0]    cur, base_r, b1, b2;
  logic [LEN_W-1:0] sz1, sz2;
  logic             ls, chain, eor;
  logic             stopped;

  assign stopped    = (state == S_IDLE) || (state == S_SUSP);
  assign mem_req    = (state == S_RD);
  assign mem_addr   = cur + AW'({widx, 2'b00});
  assign xfer_valid = ((state == S_BUF1) && (sz1 != '0)) ||
                      ((state == S_BUF2) && !chain && (sz2 != '0));
  assign xfer_addr  = (state == S_BUF2) ? b2 : b1;
  assign xfer_len   = (state == S_BUF2) ? sz2 : sz1;
  assign xfer_eof   = ls && ((state == S_BUF2) || chain || (sz2 == '0));
  assign suspended  = (state == S_SUSP);
  assign cur_desc   = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      widx   <= '0;
      cur    <= '0;
      base_r <= '0;
      b1     <= '0;
      b2     <= '0;
      sz1    <= '0;
      sz2    <= '0;
      ls     <= 1'b0;
      chain  <= 1'b0;
      eor    <= 1'b0;
    end else begin
      if (base_wr) begin
        base_r <= base_in;
        if (stopped) cur <= base_in;
      end
      case (state)
        S_IDLE, S_SUSP: begin
          if (poll) begin
            state <= S_RD;
            widx  <= '0;
          end
        end
        S_RD: begin
          if (mem_ack) begin
            case (widx)
              2'd0: begin
                ls <= mem_rdata[LS_BIT];
                if (!mem_rdata[OWN_BIT]) state <= S_SUSP;
                else widx <= 2'd1;
              end
              2'd1: begin
                sz1   <= mem_rdata[LEN_W-1:0];
                sz2   <= mem_rdata[SZ2_LO +: LEN_W];
                chain <= mem_rdata[CH_BIT];
                eor   <= mem_rdata[EOR_BIT];
                widx  <= 2'd2;
              end
              2'd2: begin
                b1   <= AW'(mem_rdata);
                widx <= 2'd3;
              end
              default: begin
                b2    <= AW'(mem_rdata);
                state <= S_BUF1;
              end
            endcase
          end
        end
        S_BUF1: if ((sz1 == '0) || xfer_done) state <= S_BUF2;
        S_BUF2: if (chain || (sz2 == '0) || xfer_done) state <= S_NEXT;
        S_NEXT: begin
          cur   <= chain ? b2 : (eor ? base_r : cur + AW'(STRIDE));
          state <= S_RD;
          widx  <= '0;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  // R5
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid && !xfer_done |=> xfer_valid && $stable(xfer_addr) && $stable(xfer_len));

  // R6
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> xfer_len != '0);

  // R4
  susp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req && !xfer_valid);

  // R2
  run_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr && xfer_valid |=> $stable(cur_desc));

endmodule

// File: tb/dlist_walker_test.sv
module dlist_walker_test;
  logic        clk = 0, rst_n = 0;
  logic        base_wr = 0, poll = 0;
  logic [31:0] base_in = '0;
  logic        mem_req, mem_ack = 0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        xfer_valid, xfer_eof, xfer_done = 0;
  logic [31:0] xfer_addr;
  logic [11:0] xfer_len;
  logic        suspended;
  logic [31:0] cur_desc;

  int tests = 0, fails = 0;
  logic [31:0] mem [256];
  logic [31:0] rlog [32];
  logic [31:0] tla [16];
  logic [11:0] tll [16];
  logic        tle [16];
  int nrd = 0, nx = 0, lag = 0, wcnt = 0;

  always #4 clk = ~clk;

  dlist_walker uut (
    .clk(clk), .rst_n(rst_n), .base_wr(base_wr), .base_in(base_in), .poll(poll),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_len(xfer_len),
    .xfer_eof(xfer_eof), .xfer_done(xfer_done), .suspended(suspended), .cur_desc(cur_desc)
  );

  always @(negedge clk) begin
    mem_ack = mem_req;
    if (mem_req) begin
      mem_rdata = mem[mem_addr[9:2]];
      if (nrd < 32) rlog[nrd] = mem_addr;
      nrd++;
    end
    if (xfer_valid) begin
      if (wcnt < lag) begin
        wcnt++;
        xfer_done = 0;
      end else begin
        wcnt = 0;
        xfer_done = 1;
        if (nx < 16) begin
          tla[nx] = xfer_addr; tll[nx] = xfer_len; tle[nx] = xfer_eof;
        end
        nx++;
      end
    end else begin
      xfer_done = 0;
      wcnt = 0;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_desc(int a, bit own, bit lseg, bit ch, bit er,
                          int s1, int s2, logic [31:0] p1, logic [31:0] p2);
    mem[a >> 2]       = {own, lseg, 30'd0};
    mem[(a >> 2) + 1] = {6'd0, er, ch, s2[11:0], s1[11:0]};
    mem[(a >> 2) + 2] = p1;
    mem[(a >> 2) + 3] = p2;
  endtask

  task automatic write_base(logic [31:0] v);
    @(negedge clk); base_wr = 1; base_in = v;
    @(negedge clk); base_wr = 0;
  endtask

  task automatic kick();
    nrd = 0; nx = 0;
    @(negedge clk); poll = 1;
    @(negedge clk); poll = 0;
  endtask

  task automatic wait_susp();
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #1;
      if (suspended) break;
    end
  endtask

  task automatic t_reset();
    check("R1 mem_req", mem_req, 0);
    check("R1 xfer_valid", xfer_valid, 0);
    check("R1 suspended", suspended, 0);
    check("R1 cur_desc", cur_desc, 0);
  endtask

  task automatic t_ring();
    write_base(32'h100);
    #1 check("R2 load idle", cur_desc, 32'h100);
    put_desc(32'h100, 1, 0, 0, 0, 8, 4, 32'h1000, 32'h2000);
    put_desc(32'h110, 1, 1, 0, 0, 0, 6, 32'h2fff, 32'h3000);
    put_desc(32'h120, 0, 0, 0, 0, 1, 1, 32'h0, 32'h0);
    lag = 0;
    kick();
    wait_susp();
    check("R4 suspended", suspended, 1);
    check("R3 read count", nrd, 9);
    for (int i = 0; i < 8; i++)
      check("R3 R8 read addr", rlog[i], 32'h100 + (i / 4) * 16 + (i % 4) * 4);
    check("R4 stop word0", rlog[8], 32'h120);
    check("R8 cur_desc", cur_desc, 32'h120);
    check("R6 xfer count", nx, 3);
    check("R5 a0", tla[0], 32'h1000); check("R5 l0", tll[0], 8); check("R9 e0", tle[0], 0);
    check("R5 a1", tla[1], 32'h2000); check("R5 l1", tll[1], 4); check("R9 e1", tle[1], 0);
    check("R6 a2", tla[2], 32'h3000); check("R6 l2", tll[2], 6); check("R9 e2", tle[2], 1);
    repeat (5) @(negedge clk);
    check("R4 no reads while suspended", nrd, 9);
  endtask

  task automatic t_chain();
    write_base(32'h200);
    #1 check("R2 load suspended", cur_desc, 32'h200);
    put_desc(32'h200, 1, 1, 1, 0, 5, 7, 32'h4000, 32'h300);
    put_desc(32'h300, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    lag = 2;
    kick();
    wait_susp();
    check("R7 xfer count", nx, 1);
    check("R7 addr", tla[0], 32'h4000);
    check("R7 len", tll[0], 5);
    check("R9 chained eof", tle[0], 1);
    check("R7 next ptr", cur_desc, 32'h300);
    check("R7 read next", rlog[4], 32'h300);
  endtask

  task automatic t_resume_wrap();
    mem[32'h200 >> 2] = 32'h0;
    put_desc(32'h300, 1, 1, 0, 1, 3, 0, 32'h5000, 32'h0);
    lag = 0;
    kick();
    wait_susp();
    check("R4 refetch word0", rlog[0], 32'h300);
    check("R4 resume xfer", tla[0], 32'h5000);
    check("R9 eof only buf", tle[0], 1);
    check("R8 wrap to base", cur_desc, 32'h200);
    check("R8 wrap read", rlog[4], 32'h200);
  endtask

  task automatic t_run_write();
    write_base(32'h100);
    #1 check("R2 reload", cur_desc, 32'h100);
    put_desc(32'h100, 1, 1, 0, 0, 2, 0, 32'h6000, 32'h0);
    put_desc(32'h110, 0, 0, 0, 0, 0, 0, 32'h0, 32'h0);
    lag = 20;
    kick();
    for (int i = 0; i < 200; i++) begin
      @(posedge clk); #1;
      if (xfer_valid) break;
    end
    write_base(32'h380);
    #1 check("R2 ignored while running", cur_desc, 32'h100);
    check("R5 still offered", xfer_valid, 1);
    wait_susp();
    check("R2 walk continued", cur_desc, 32'h110);
    check("R5 held xfer", tla[0], 32'h6000);
    check("R6 single xfer", nx, 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_ring();
    t_chain();
    t_resume_wrap();
    t_run_write();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule